// File: doc/BRIEF.md
# Asynchronous serial receiver with sticky framing-error flag

This block takes a serial line that idles high and turns it into parallel data. It works from a 16x oversampling tick. Two frame shapes are supported. In the 8-bit shape (mode 1), a start bit is followed by eight data bits and a stop bit. In the 9-bit shape (modes 2 and 3), nine data bits sit between the start bit and the stop bit, and the ninth bit is delivered on its own output. Mode 0 is a synchronous shift mode that is handled elsewhere, so this receiver ignores the line while mode 0 is selected.

A framing check can be switched on. When it is on, each frame's stop bit is voted, and a stop bit that reads 0 raises a sticky error flag. Only a clear strobe or reset lowers that flag. Turning the check on also moves the moment the receive-complete flag rises: it rises at the stop-bit sample instead of at the last data bit. A shared control bit reads back either the error flag or the upper mode-select bit, and the check enable chooses which one. The receive side runs on its own tick, independently of any transmitter.

Top module: `serial_rx_fe`

## Requirements
- R1: After reset, rx_done, ferr, rx_data, rx_bit9 and ctl_shared are all 0.
- R2: With mode_sel=01, a frame is a low start bit, then eight data bits sent least-significant bit first, then a stop bit. The eight data bits appear on rx_data.
- R3: With mode_sel=10 or 11, nine data bits are received least-significant bit first. The low eight go to rx_data and the ninth goes to rx_bit9.
- R4: With mode_sel=00, no frame is received: rx_done stays 0 and rx_data is unchanged.
- R5: With fe_chk_en=1, a stop bit voted 0 sets ferr, and a stop bit voted 1 leaves ferr at 0. With fe_chk_en=0, ferr is never set.
- R6: Once ferr is set, it stays 1 through later frames with valid stop bits, until a clr_ferr pulse clears it.
- R7: With fe_chk_en=1, rx_done rises at the stop-bit vote, so it is still 0 when the stop bit begins. With fe_chk_en=0, rx_done rises at the vote of the last data bit, so it is already 1 when the stop bit begins.
- R8: rx_done stays 1 until a clr_done pulse. While rx_en=0, no frame is accepted and no flag or data output changes.
- R9: A start bit that votes 1 at mid-bit is treated as a glitch. The receiver returns to idle without raising any flag and then accepts the next real frame.
- R10: Each bit is a 2-of-3 majority vote over the line at oversampling ticks 7, 8 and 9 of its 16 (counting from 0). A single deviating sample, including one in the start or stop bit, changes nothing.
- R11: The receiver is idle again right after the stop-bit vote. A new start edge that arrives 12 ticks into the stop bit is accepted and received correctly.
- R12: ctl_shared returns ferr while fe_chk_en=1 and mode_sel[1] while fe_chk_en=0, one clock after its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_serial | input | 1 | Serial line, idles high |
| os_tick | input | 1 | One-clock pulse at 16x the bit rate |
| mode_sel | input | 2 | 00 sync (ignored), 01 8-bit, 10/11 9-bit |
| rx_en | input | 1 | Reception enable |
| fe_chk_en | input | 1 | Framing check enable |
| clr_done | input | 1 | Clear strobe for rx_done |
| clr_ferr | input | 1 | Clear strobe for ferr |
| rx_data | output | 8 | Received data byte |
| rx_bit9 | output | 1 | Ninth data bit (9-bit modes) |
| rx_done | output | 1 | Sticky receive-complete flag |
| ferr | output | 1 | Sticky framing-error flag |
| ctl_shared | output | 1 | Shared control bit readback |

## Verification
The line passes through a two-stage synchronizer. Each bit's vote is registered one clock after the tick that takes its third sample, and the flags and data register one clock after that. A decision is therefore due about three clocks after the tenth tick of a bit, which is roughly 41 of the 64 clocks in a bit. The bench generates the ticks itself in lock-step with the line. It checks each result at a falling clock edge once a whole bit period, or the whole stop bit, has elapsed. The one exception is rx_done: it is checked at the start of the stop bit, where its value tells the two timing choices apart. The shared bit is checked a few clocks after its inputs change.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_s,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      prev <= 1'b1;
    end else begin
      sh   <= {sh[STAGES-2:0], line_in};
      prev <= sh[STAGES-1];
    end
  end

  assign line_s = sh[STAGES-1];
  assign fall   = prev & ~sh[STAGES-1];
endmodule

// File: rtl/serial_rx_sampler.sv
module serial_rx_sampler
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  input  logic line_s,
  output logic vote_valid,
  output logic vote_bit
);
  localparam int CW = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam logic [CW-1:0] PT_A = CW'(MID - 1);
  localparam logic [CW-1:0] PT_B = CW'(MID);
  localparam logic [CW-1:0] PT_C = CW'(MID + 1);
  localparam logic [CW-1:0] PT_END = CW'(OSR - 1);

  logic [CW-1:0] cnt;
  logic          smp_a, smp_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      smp_a      <= 1'b1;
      smp_b      <= 1'b1;
      vote_valid <= 1'b0;
      vote_bit   <= 1'b1;
    end else begin
      vote_valid <= 1'b0;
      if (restart) begin
        cnt <= '0;
      end else if (tick) begin
        cnt <= (cnt == PT_END) ? '0 : cnt + 1'b1;
        if (cnt == PT_A) smp_a <= line_s;
        if (cnt == PT_B) smp_b <= line_s;
        if (cnt == PT_C) begin
          vote_valid <= 1'b1;
          vote_bit   <= vote3(smp_a, smp_b, line_s);
        end
      end
    end
  end
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic              vote_valid,
  input  logic              vote_bit,
  input  logic [1:0]        mode_sel,
  input  logic              rx_en,
  input  logic              fe_chk_en,
  input  logic              clr_done,
  input  logic              clr_ferr,
  output logic              restart,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_done,
  output logic              ferr
);
  localparam int IW = $clog2(DATA_W + 2);
  localparam logic [IW-1:0] LAST8 = IW'(DATA_W - 1);
  localparam logic [IW-1:0] LAST9 = IW'(DATA_W);

  rx_state_t         state;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] sh;
  logic [DATA_W:0]   sh_nx;
  logic [DATA_W-1:0] data_nx, cap_data;
  logic              cap_b9;
  logic              nine, last;

  assign nine    = mode_sel[1];
  assign sh_nx   = {vote_bit, sh};
  assign data_nx = nine ? sh_nx[DATA_W-1:0] : sh_nx[DATA_W:1];
  assign last    = nine ? (idx == LAST9) : (idx == LAST8);
  assign restart = (state == RX_IDLE) && fall && rx_en && (mode_sel != 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      idx      <= '0;
      sh       <= '0;
      cap_data <= '0;
      cap_b9   <= 1'b0;
      rx_data  <= '0;
      rx_bit9  <= 1'b0;
      rx_done  <= 1'b0;
      ferr     <= 1'b0;
    end else begin
      if (clr_done) rx_done <= 1'b0;
      if (clr_ferr) ferr <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (restart) state <= RX_START;
        end
        RX_START: begin
          if (vote_valid) begin
            if (vote_bit) state <= RX_IDLE;
            else begin
              state <= RX_DATA;
              idx   <= '0;
            end
          end
        end
        RX_DATA: begin
          if (vote_valid) begin
            sh  <= sh_nx[DATA_W:1];
            idx <= idx + 1'b1;
            if (last) begin
              state    <= RX_STOP;
              cap_data <= data_nx;
              cap_b9   <= sh_nx[DATA_W];
              if (!fe_chk_en && rx_en) begin
                rx_data <= data_nx;
                if (nine) rx_bit9 <= sh_nx[DATA_W];
                rx_done <= 1'b1;
              end
            end
          end
        end
        RX_STOP: begin
          if (vote_valid) begin
            state <= RX_IDLE;
            if (fe_chk_en && rx_en) begin
              rx_data <= cap_data;
              if (nine) rx_bit9 <= cap_b9;
              rx_done <= 1'b1;
              if (!vote_bit) ferr <= 1'b1;
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_fe.sv
module serial_rx_fe #(
  parameter int DATA_W = 8,
  parameter int OSR = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_serial,
  input  logic              os_tick,
  input  logic [1:0]        mode_sel,
  input  logic              rx_en,
  input  logic              fe_chk_en,
  input  logic              clr_done,
  input  logic              clr_ferr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_done,
  output logic              ferr,
  output logic              ctl_shared
);
  logic line_s, fall, restart, vote_valid, vote_bit;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_in(rx_serial), .line_s(line_s), .fall(fall)
  );

  serial_rx_sampler #(.OSR(OSR)) u_smp (
    .clk(clk), .rst(rst), .restart(restart), .tick(os_tick), .line_s(line_s),
    .vote_valid(vote_valid), .vote_bit(vote_bit)
  );

  serial_rx_frame #(.DATA_W(DATA_W)) u_frm (
    .clk(clk), .rst(rst), .fall(fall), .vote_valid(vote_valid), .vote_bit(vote_bit),
    .mode_sel(mode_sel), .rx_en(rx_en), .fe_chk_en(fe_chk_en),
    .clr_done(clr_done), .clr_ferr(clr_ferr), .restart(restart),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_done(rx_done), .ferr(ferr)
  );

  always_ff @(posedge clk) begin
    if (rst) ctl_shared <= 1'b0;
    else     ctl_shared <= fe_chk_en ? ferr : mode_sel[1];
  end
endmodule

// File: rtl/serial_rx_fe_chk.sv
module serial_rx_fe_chk (
  input logic clk,
  input logic rst,
  input logic rx_en,
  input logic fe_chk_en,
  input logic clr_done,
  input logic clr_ferr,
  input logic rx_done,
  input logic ferr
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!rx_done && !ferr));

  // R6
  ferr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ferr && !clr_ferr) |=> ferr);

  // R5
  ferr_needs_check_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ferr) |-> $past(fe_chk_en));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !clr_done) |=> rx_done);

  // R8
  done_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_done) |-> $past(rx_en));
endmodule

bind serial_rx_fe serial_rx_fe_chk u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .fe_chk_en(fe_chk_en),
  .clr_done(clr_done), .clr_ferr(clr_ferr), .rx_done(rx_done), .ferr(ferr)
);

// File: tb/serial_rx_fe_tb.sv
`timescale 1ns/1ps
module serial_rx_fe_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_serial = 1'b1;
  logic os_tick = 1'b0;
  logic [1:0] mode_sel = 2'b01;
  logic rx_en = 1'b1;
  logic fe_chk_en = 1'b0;
  logic clr_done = 1'b0;
  logic clr_ferr = 1'b0;
  logic [7:0] rx_data;
  logic rx_bit9, rx_done, ferr, ctl_shared;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  serial_rx_fe u_dut (
    .clk(clk), .rst(rst), .rx_serial(rx_serial), .os_tick(os_tick),
    .mode_sel(mode_sel), .rx_en(rx_en), .fe_chk_en(fe_chk_en),
    .clr_done(clr_done), .clr_ferr(clr_ferr), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_done(rx_done), .ferr(ferr), .ctl_shared(ctl_shared)
  );

  // vector: [13:12] mode, [11] check enable, [10] stop value, [8:0] data
  localparam logic [13:0] VEC [8] = '{
    {2'd1, 1'b1, 1'b1, 1'b0, 9'h0A5},
    {2'd1, 1'b1, 1'b0, 1'b0, 9'h03C},
    {2'd1, 1'b0, 1'b0, 1'b0, 9'h0FF},
    {2'd1, 1'b0, 1'b1, 1'b0, 9'h000},
    {2'd2, 1'b1, 1'b1, 1'b0, 9'h1C3},
    {2'd3, 1'b0, 1'b1, 1'b0, 9'h15A},
    {2'd3, 1'b1, 1'b0, 1'b0, 9'h001},
    {2'd2, 1'b0, 1'b1, 1'b0, 9'h100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      rx_serial = v;
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  // one bit of 16 ticks; with glit, tick 8 carries the inverted value
  task automatic send_bit(input logic v, input bit glit);
    if (glit) begin
      ticks(v, 8); ticks(~v, 1); ticks(v, 7);
    end else ticks(v, 16);
  endtask

  task automatic send_frame(input logic [8:0] d, input int nb, input logic stopv,
                            input int stop_ticks, input bit glit, output logic pre_done);
    send_bit(1'b0, glit);
    for (int i = 0; i < nb; i++) send_bit(d[i], glit);
    pre_done = rx_done;
    if (glit && stop_ticks == 16) send_bit(stopv, 1'b1);
    else ticks(stopv, stop_ticks);
  endtask

  task automatic pulse_clears();
    clr_done = 1'b1; clr_ferr = 1'b1;
    @(negedge clk);
    clr_done = 1'b0; clr_ferr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic pre;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", rx_done, 0);
    chk("R1 ferr", ferr, 0);
    chk("R1 data", rx_data, 0);
    chk("R1 bit9", rx_bit9, 0);
    chk("R1 shared", ctl_shared, 0);
    ticks(1'b1, 4);

    // table walk: R2 R3 R5 R7
    for (int k = 0; k < 8; k++) begin
      logic [13:0] v;
      int nb;
      v = VEC[k];
      mode_sel = v[13:12];
      fe_chk_en = v[11];
      nb = v[13] ? 9 : 8;
      pulse_clears();
      chk("R8 cleared", rx_done, 0);
      send_frame(v[8:0], nb, v[10], 16, 1'b0, pre);
      chk("R7 done at stop start", pre, !v[11]);
      chk("R2/R3 done", rx_done, 1);
      chk("R2/R3 data", rx_data, v[7:0]);
      if (v[13]) chk("R3 bit9", rx_bit9, v[8]);
      chk("R5 ferr", ferr, v[11] & ~v[10]);
      ticks(1'b1, 4);
    end

    // R6 sticky framing error
    mode_sel = 2'b01; fe_chk_en = 1'b1;
    pulse_clears();
    send_frame(9'h011, 8, 1'b0, 16, 1'b0, pre);
    ticks(1'b1, 4);
    chk("R6 set", ferr, 1);
    send_frame(9'h022, 8, 1'b1, 16, 1'b0, pre);
    ticks(1'b1, 4);
    chk("R6 held after good frame", ferr, 1);
    chk("R6 data", rx_data, 8'h22);
    // R12 shared bit shows ferr
    chk("R12 shared=ferr", ctl_shared, 1);
    clr_ferr = 1'b1; @(negedge clk); clr_ferr = 1'b0; @(negedge clk); @(negedge clk);
    chk("R6 cleared", ferr, 0);
    chk("R12 shared follows ferr", ctl_shared, 0);
    fe_chk_en = 1'b0; mode_sel = 2'b10;
    repeat (2) @(negedge clk);
    chk("R12 shared=mode bit1", ctl_shared, 1);
    mode_sel = 2'b01;
    repeat (2) @(negedge clk);
    chk("R12 shared=mode bit1 low", ctl_shared, 0);

    // R8 sticky done, and disable
    chk("R8 done held", rx_done, 1);
    pulse_clears();
    chk("R8 done cleared", rx_done, 0);
    rx_en = 1'b0;
    send_frame(9'h077, 8, 1'b1, 16, 1'b0, pre);
    ticks(1'b1, 4);
    chk("R8 disabled done", rx_done, 0);
    chk("R8 disabled data", rx_data, 8'h22);
    rx_en = 1'b1;

    // R4 mode 0 ignored
    mode_sel = 2'b00;
    send_frame(9'h0E1, 8, 1'b1, 16, 1'b0, pre);
    ticks(1'b1, 4);
    chk("R4 done", rx_done, 0);
    chk("R4 data", rx_data, 8'h22);
    mode_sel = 2'b01;

    // R9 start glitch then real frame
    ticks(1'b0, 4);
    ticks(1'b1, 20);
    chk("R9 glitch done", rx_done, 0);
    send_frame(9'h0C7, 8, 1'b1, 16, 1'b0, pre);
    ticks(1'b1, 4);
    chk("R9 next frame done", rx_done, 1);
    chk("R9 next frame data", rx_data, 8'hC7);

    // R10 single deviant sample per bit, including stop
    fe_chk_en = 1'b1;
    pulse_clears();
    send_frame(9'h0A5, 8, 1'b1, 16, 1'b1, pre);
    ticks(1'b1, 4);
    chk("R10 data", rx_data, 8'hA5);
    chk("R10 ferr", ferr, 0);
    chk("R10 done", rx_done, 1);
    mode_sel = 2'b11;
    pulse_clears();
    send_frame(9'h14B, 9, 1'b1, 16, 1'b1, pre);
    ticks(1'b1, 4);
    chk("R10 data9", rx_data, 8'h4B);
    chk("R10 bit9", rx_bit9, 1);

    // R11 short stop bit, back-to-back
    mode_sel = 2'b01;
    pulse_clears();
    send_frame(9'h05C, 8, 1'b1, 12, 1'b0, pre);
    chk("R11 first data", rx_data, 8'h5C);
    clr_done = 1'b1; @(negedge clk); clr_done = 1'b0;
    send_frame(9'h0B3, 8, 1'b1, 16, 1'b0, pre);
    ticks(1'b1, 4);
    chk("R11 second done", rx_done, 1);
    chk("R11 second data", rx_data, 8'hB3);
    chk("R11 ferr", ferr, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule